// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block decides when a UART may transmit and when it asks its peer to pause. It sits beside the receive and transmit FIFOs (128 words each) and the shift registers, but it contains none of them. It watches the receive FIFO fill level, the stream of received characters and the incoming clear-to-send line. From these it drives the request-to-send line, a transmit-permission signal, a request to inject a flow-control character into the transmit stream, and a strobe that tells the receive FIFO whether a received character should be stored.

**Hardware flow control.** Two 4-bit thresholds, each counted in steps of 8 words, give hysteresis on the request-to-send line.

**Software flow control.** Received characters are compared with four programmable characters: two "resume" characters and two "pause" characters. A match pauses or resumes the local transmitter and raises a flag. The matched character is not stored. A separate setting chooses which of the characters the block emits towards the peer when the receive FIFO crosses the same thresholds. In the "all four" setting, a pause or resume is recognised only as a two-character pair: the first character of the set, then the second one on the very next received character.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters this state: `rts_o`=1, `tx_allow`=1, `send_req`=0, `spc_flags`=0, `rx_wr`=0.
- R2: The halt threshold is `flow_lvl[3:0]`×8 words, and a field value of 0 means 128 words. With `cfg_auto_rts`=1 and `rts_o`=1, a level at or above the halt threshold drives `rts_o` to 0 one cycle later.
- R3: The resume threshold is `flow_lvl[7:4]`×8 words. Once `rts_o` is 0, it stays 0 while the level is above the resume threshold, and it returns to 1 one cycle after the level is at or below the resume threshold.
- R4: With `cfg_auto_rts`=0, `rts_o` is 1 one cycle later, whatever the level.
- R5: With `cfg_auto_cts`=1 and `cts_i`=0, `tx_allow` is 0 one cycle later. With `cfg_auto_cts`=0, `cts_i` has no effect on `tx_allow`.
- R6: With `cfg_sw_en`=1 and `cfg_rx_sel` set to 2'b10 (first set) or 2'b01 (second set), a received character equal to that set's pause character or resume character is handled in the cycle after its strobe: the transmitter pauses or resumes, the flag bit is set, and `rx_wr`=0. Flag bits: bit0 first resume, bit1 second resume, bit2 first pause, bit3 second pause. Any other character gives `rx_wr`=1 with its data and no flag.
- R7: With `cfg_rx_sel`=2'b11, a pause needs the first pause character followed by the second pause character as the next received character. The result is flags 4'b1100, a paused transmitter, and the second character not stored. A resume works the same way with the resume characters and gives flags 4'b0011. Any other next character cancels the pending pair.
- R8: With `cfg_sw_en`=0 or `cfg_rx_sel`=2'b00, every received character is stored and raises no flag, and the software pause is cleared.
- R9: `tx_allow` is 0 exactly when the clear-to-send gate is closed or the software pause is set.
- R10: With `cfg_sw_en`=1 and `cfg_tx_sel`≠0, the level reaching the halt threshold makes `send_req` rise two cycles later. The pause characters sent are: 01 → second pause, 10 → first pause, 11 → first pause then second pause.
- R11: With the same settings, the level falling to the resume threshold requests the resume characters in the same pattern, two cycles later.
- R12: `send_req` and `send_char` hold steady until `send_ack`. Each acknowledge advances to the next queued character or drops `send_req` after the last one.
- R13: A new threshold crossing while characters are still queued replaces the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 8 | Receive FIFO fill level in words (0 to 128) |
| flow_lvl | input | 8 | [3:0] halt threshold, [7:4] resume threshold, in units of 8 words |
| cfg_auto_rts | input | 1 | Enables automatic request-to-send control |
| cfg_auto_cts | input | 1 | Enables gating of the transmitter on clear-to-send |
| cfg_sw_en | input | 1 | Enables software flow control |
| cfg_rx_sel | input | 2 | Which characters are matched on receive |
| cfg_tx_sel | input | 2 | Which characters are emitted towards the peer |
| xon1_chr | input | 8 | First resume character |
| xon2_chr | input | 8 | Second resume character |
| xoff1_chr | input | 8 | First pause character |
| xoff2_chr | input | 8 | Second pause character |
| rx_valid | input | 1 | Strobe: a received character is presented |
| rx_char | input | 8 | Received character |
| cts_i | input | 1 | Clear-to-send from the peer, 1 = clear |
| send_ack | input | 1 | Transmitter has taken `send_char` |
| rts_o | output | 1 | Request-to-send towards the peer, 1 = ready to receive |
| tx_allow | output | 1 | Transmitter may start a new character |
| send_req | output | 1 | A flow-control character is waiting to be sent |
| send_char | output | 8 | Flow-control character to send |
| spc_flags | output | 4 | One-cycle flags for matched special characters |
| rx_wr | output | 1 | Store the received character in the receive FIFO |
| rx_wr_data | output | 8 | Character to store |

## Verification
Each result appears at its own delay after the input that causes it:
- `rts_o`, `spc_flags`, `rx_wr` and the pause part of `tx_allow` change one edge after the level, the strobe or the clear-to-send value is applied.
- `send_req` rises two edges after a threshold crossing, because the crossing is first registered as an event and the queue loads on the following edge.
- An acknowledge advances `send_char` on the edge at which it is seen.

The bench drives inputs just after a falling edge and samples on the next falling edge. A behavioural model, updated on the same rising edge, reproduces these delays. The directed checks count the same edges before they compare.

// File: rtl/flow_pkg.sv
// Shared constants and types for the UART flow controller.
// Assumes 8-bit characters; FIFO depth is a parameter of the top.
package flow_pkg;
    localparam int FIFO_WORDS_DFLT = 128;
    localparam int STEP_WORDS      = 8;
    localparam int CHAR_W_DFLT     = 8;

    // Flag bit positions, decoded by the interrupt logic downstream.
    localparam int FLG_XON1  = 0;
    localparam int FLG_XON2  = 1;
    localparam int FLG_XOFF1 = 2;
    localparam int FLG_XOFF2 = 3;
    localparam int FLG_W     = 4;

    // Character-set selection encoding, shared by receive and transmit.
    typedef enum logic [1:0] {
        SEL_NONE  = 2'b00,
        SEL_PAIR2 = 2'b01,
        SEL_PAIR1 = 2'b10,
        SEL_ALL   = 2'b11
    } sel_e;
endpackage

// File: rtl/fc_hyst.sv
// Threshold tracker with hysteresis on the receive FIFO level.
// Sets 'halted' when the level reaches halt_w and clears it when the
// level falls to resume_w or below. It gives one-cycle pulses on each
// change. When disabled it clears without a pulse.
module fc_hyst #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] halt_w,
    input  logic [LVL_W-1:0] resume_w,
    output logic             halted,
    output logic             enter_p,
    output logic             leave_p
);
    // Track the halted state and emit the transition pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted  <= 1'b0;
            enter_p <= 1'b0;
            leave_p <= 1'b0;
        end else begin
            enter_p <= 1'b0;
            leave_p <= 1'b0;
            if (!en) begin
                halted <= 1'b0;
            end else if (!halted && level >= halt_w) begin
                halted  <= 1'b1;
                enter_p <= 1'b1;
            end else if (halted && level <= resume_w) begin
                halted  <= 1'b0;
                leave_p <= 1'b1;
            end
        end
    end

    a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !halted && level >= halt_w) |=> halted);
    a_r3_hold_above_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (en && halted && level > resume_w) |=> halted);
endmodule

// File: rtl/fc_char_match.sv
// Receive-side special-character matcher.
// In the single-set modes one character pauses or resumes the local
// transmitter. In the all-characters mode a two-character pair is
// needed. A matched character is withheld from the receive FIFO.
// The outputs are registered, one cycle after the strobe.
module fc_char_match
    import flow_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic [1:0]        sel_i,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              paused_o,
    output logic [FLG_W-1:0]  flags_o,
    output logic              wr_o,
    output logic [CHAR_W-1:0] wr_data_o
);
    logic             active, pair_mode;
    logic             hit_on, hit_off, nxt_pon, nxt_poff;
    logic             pend_on, pend_off;
    logic [FLG_W-1:0] flg;

    assign active    = sw_en && (sel_i != SEL_NONE);
    assign pair_mode = active && (sel_i == SEL_ALL);

    // Decode the received character against the selected set.
    always_comb begin
        hit_on   = 1'b0;
        hit_off  = 1'b0;
        nxt_pon  = 1'b0;
        nxt_poff = 1'b0;
        flg      = '0;
        if (active) begin
            case (sel_i)
                SEL_PAIR2: begin
                    if (rx_char == xoff2) begin
                        hit_off = 1'b1; flg[FLG_XOFF2] = 1'b1;
                    end else if (rx_char == xon2) begin
                        hit_on = 1'b1; flg[FLG_XON2] = 1'b1;
                    end
                end
                SEL_PAIR1: begin
                    if (rx_char == xoff1) begin
                        hit_off = 1'b1; flg[FLG_XOFF1] = 1'b1;
                    end else if (rx_char == xon1) begin
                        hit_on = 1'b1; flg[FLG_XON1] = 1'b1;
                    end
                end
                SEL_ALL: begin
                    if (pend_off && rx_char == xoff2) begin
                        hit_off = 1'b1;
                        flg[FLG_XOFF1] = 1'b1; flg[FLG_XOFF2] = 1'b1;
                    end else if (pend_on && rx_char == xon2) begin
                        hit_on = 1'b1;
                        flg[FLG_XON1] = 1'b1; flg[FLG_XON2] = 1'b1;
                    end else begin
                        nxt_poff = (rx_char == xoff1);
                        nxt_pon  = (rx_char == xon1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the pause state, pending pair halves and FIFO write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused_o  <= 1'b0;
            flags_o   <= '0;
            wr_o      <= 1'b0;
            wr_data_o <= '0;
            pend_on   <= 1'b0;
            pend_off  <= 1'b0;
        end else begin
            wr_o    <= 1'b0;
            flags_o <= '0;
            if (!pair_mode) begin
                pend_on  <= 1'b0;
                pend_off <= 1'b0;
            end else if (rx_valid) begin
                pend_on  <= nxt_pon;
                pend_off <= nxt_poff;
            end
            if (rx_valid) begin
                wr_o      <= !(hit_on || hit_off);
                wr_data_o <= rx_char;
                flags_o   <= flg;
            end
            if (!active)
                paused_o <= 1'b0;
            else if (rx_valid && hit_off)
                paused_o <= 1'b1;
            else if (rx_valid && hit_on)
                paused_o <= 1'b0;
        end
    end

    a_r6_match_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o != '0) |-> !wr_o);
    a_r7_lone_char_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && rx_valid && !pend_on && !pend_off) |=> (flags_o == '0));
    a_r8_inactive_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !active) |=> (wr_o && flags_o == '0 && !paused_o));
endmodule

// File: rtl/fc_send_seq.sv
// Queue of flow-control characters to send to the peer.
// A pause or resume event loads one or two characters, chosen by the
// transmit selection, and replaces whatever was still queued. The head
// character is held on send_char until the transmitter acknowledges it.
module fc_send_seq
    import flow_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_i,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic              ev_off,
    input  logic              ev_on,
    input  logic              send_ack,
    output logic              send_req,
    output logic [CHAR_W-1:0] send_char
);
    logic [1:0]        cnt;
    logic [CHAR_W-1:0] head, tail;
    logic [CHAR_W-1:0] c_first, c_second;

    // Choose the character pair for the current event.
    always_comb begin
        c_first  = ev_off ? xoff1 : xon1;
        c_second = ev_off ? xoff2 : xon2;
    end

    // Load on an event, otherwise advance on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            head <= '0;
            tail <= '0;
        end else if (ev_off || ev_on) begin
            case (sel_i)
                SEL_PAIR2: begin cnt <= 2'd1; head <= c_second; end
                SEL_PAIR1: begin cnt <= 2'd1; head <= c_first;  end
                SEL_ALL:   begin cnt <= 2'd2; head <= c_first; tail <= c_second; end
                default:   cnt <= 2'd0;
            endcase
        end else if (send_ack && cnt != 2'd0) begin
            cnt  <= cnt - 2'd1;
            head <= tail;
        end
    end

    assign send_req  = (cnt != 2'd0);
    assign send_char = head;

    a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && !send_ack && !ev_off && !ev_on) |=> (send_req && $stable(send_char)));
    a_r10_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_off && sel_i == SEL_ALL) |=> (send_req && send_char == $past(xoff1)));
endmodule

// File: rtl/uart_flow_ctrl.sv
// UART automatic flow controller (top).
// Combines request-to-send hysteresis, clear-to-send gating, receive
// character matching and the queue of characters to send. Assumes the
// FIFO level is a plain count from 0 to FIFO_WORDS and that the
// transmitter only consults tx_allow before starting a character.
module uart_flow_ctrl
    import flow_pkg::*;
#(
    parameter int FIFO_WORDS = FIFO_WORDS_DFLT,
    parameter int CHAR_W     = CHAR_W_DFLT,
    localparam int LVL_W     = $clog2(FIFO_WORDS + 1),
    localparam int STEP_SH   = $clog2(STEP_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [7:0]        flow_lvl,
    input  logic              cfg_auto_rts,
    input  logic              cfg_auto_cts,
    input  logic              cfg_sw_en,
    input  logic [1:0]        cfg_rx_sel,
    input  logic [1:0]        cfg_tx_sel,
    input  logic [CHAR_W-1:0] xon1_chr,
    input  logic [CHAR_W-1:0] xon2_chr,
    input  logic [CHAR_W-1:0] xoff1_chr,
    input  logic [CHAR_W-1:0] xoff2_chr,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              cts_i,
    input  logic              send_ack,
    output logic              rts_o,
    output logic              tx_allow,
    output logic              send_req,
    output logic [CHAR_W-1:0] send_char,
    output logic [FLG_W-1:0]  spc_flags,
    output logic              rx_wr,
    output logic [CHAR_W-1:0] rx_wr_data
);
    logic [LVL_W-1:0] halt_w, resume_w;
    logic             rts_halted, rts_enter, rts_leave;
    logic             sw_halted, sw_enter, sw_leave, sw_tx_en;
    logic             cts_ok_q, sw_paused;

    // A zero halt field stands for a completely full FIFO.
    assign halt_w   = (flow_lvl[3:0] == 4'd0) ? LVL_W'(FIFO_WORDS)
                                              : (LVL_W'(flow_lvl[3:0]) << STEP_SH);
    assign resume_w = LVL_W'(flow_lvl[7:4]) << STEP_SH;
    assign sw_tx_en = cfg_sw_en && (cfg_tx_sel != SEL_NONE);

    fc_hyst #(.LVL_W(LVL_W)) u_rts_hyst (
        .clk(clk), .rst_n(rst_n), .en(cfg_auto_rts), .level(rx_level),
        .halt_w(halt_w), .resume_w(resume_w),
        .halted(rts_halted), .enter_p(rts_enter), .leave_p(rts_leave)
    );

    fc_hyst #(.LVL_W(LVL_W)) u_sw_hyst (
        .clk(clk), .rst_n(rst_n), .en(sw_tx_en), .level(rx_level),
        .halt_w(halt_w), .resume_w(resume_w),
        .halted(sw_halted), .enter_p(sw_enter), .leave_p(sw_leave)
    );

    fc_char_match #(.CHAR_W(CHAR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .sw_en(cfg_sw_en), .sel_i(cfg_rx_sel),
        .xon1(xon1_chr), .xon2(xon2_chr), .xoff1(xoff1_chr), .xoff2(xoff2_chr),
        .rx_valid(rx_valid), .rx_char(rx_char),
        .paused_o(sw_paused), .flags_o(spc_flags),
        .wr_o(rx_wr), .wr_data_o(rx_wr_data)
    );

    fc_send_seq #(.CHAR_W(CHAR_W)) u_send (
        .clk(clk), .rst_n(rst_n), .sel_i(cfg_tx_sel),
        .xon1(xon1_chr), .xon2(xon2_chr), .xoff1(xoff1_chr), .xoff2(xoff2_chr),
        .ev_off(sw_enter), .ev_on(sw_leave), .send_ack(send_ack),
        .send_req(send_req), .send_char(send_char)
    );

    // Register the clear-to-send gate so the pin is sampled once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cts_ok_q <= 1'b1;
        else        cts_ok_q <= !cfg_auto_cts || cts_i;
    end

    assign rts_o    = !rts_halted;
    assign tx_allow = cts_ok_q && !sw_paused;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rts_o && tx_allow && !send_req && spc_flags == '0 && !rx_wr));
    a_r2_rts_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_rts && rts_o && rx_level >= halt_w) |=> !rts_o);
    a_r3_leave_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_leave || rts_enter) |-> (rts_o == rts_leave));
    a_r4_manual_rts: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_auto_rts |=> rts_o);
    a_r5_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_cts && !cts_i) |=> !tx_allow);
    a_r9_sw_pause_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sw_paused |-> !tx_allow);
    a_r11_sw_state: assert property (@(posedge clk) disable iff (!rst_n)
        sw_leave |-> !sw_halted);
endmodule

// File: tb/tb_uart_flow_ctrl.sv
module tb_uart_flow_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h91, XOFF1 = 8'h13, XOFF2 = 8'h93;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] rx_level = '0, flow_lvl = '0;
    logic cfg_auto_rts = 0, cfg_auto_cts = 0, cfg_sw_en = 0;
    logic [1:0] cfg_rx_sel = 0, cfg_tx_sel = 0;
    logic [7:0] xon1_chr = XON1, xon2_chr = XON2, xoff1_chr = XOFF1, xoff2_chr = XOFF2;
    logic rx_valid = 0;
    logic [7:0] rx_char = '0;
    logic cts_i = 1, send_ack = 0;
    logic rts_o, tx_allow, send_req, rx_wr;
    logic [7:0] send_char, rx_wr_data;
    logic [3:0] spc_flags;

    uart_flow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .flow_lvl(flow_lvl),
        .cfg_auto_rts(cfg_auto_rts), .cfg_auto_cts(cfg_auto_cts), .cfg_sw_en(cfg_sw_en),
        .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel),
        .xon1_chr(xon1_chr), .xon2_chr(xon2_chr), .xoff1_chr(xoff1_chr), .xoff2_chr(xoff2_chr),
        .rx_valid(rx_valid), .rx_char(rx_char), .cts_i(cts_i), .send_ack(send_ack),
        .rts_o(rts_o), .tx_allow(tx_allow), .send_req(send_req), .send_char(send_char),
        .spc_flags(spc_flags), .rx_wr(rx_wr), .rx_wr_data(rx_wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    bit m_rts_h, m_sw_h, m_paused, m_pon, m_poff, m_ctsok, m_wr;
    int m_ev, m_flags, m_wrd, hw, rw, c;
    bit act, done, en2;
    byte unsigned m_q[$];

    task automatic load_q(input bit pause);
        m_q.delete();
        case (cfg_tx_sel)
            2'b01: m_q.push_back(pause ? xoff2_chr : xon2_chr);
            2'b10: m_q.push_back(pause ? xoff1_chr : xon1_chr);
            2'b11: begin
                m_q.push_back(pause ? xoff1_chr : xon1_chr);
                m_q.push_back(pause ? xoff2_chr : xon2_chr);
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rts_h = 0; m_sw_h = 0; m_paused = 0; m_pon = 0; m_poff = 0;
            m_ctsok = 1; m_wr = 0; m_ev = 0; m_flags = 0; m_wrd = 0; m_q.delete();
        end else begin
            hw = (flow_lvl[3:0] == 0) ? 128 : flow_lvl[3:0] * 8;
            rw = flow_lvl[7:4] * 8;
            if (m_ev == 1) load_q(1);
            else if (m_ev == 2) load_q(0);
            else if (send_ack && m_q.size() > 0) void'(m_q.pop_front());
            if (!cfg_auto_rts) m_rts_h = 0;
            else if (!m_rts_h && rx_level >= hw) m_rts_h = 1;
            else if (m_rts_h && rx_level <= rw) m_rts_h = 0;
            m_ev = 0;
            en2 = cfg_sw_en && cfg_tx_sel != 0;
            if (!en2) m_sw_h = 0;
            else if (!m_sw_h && rx_level >= hw) begin m_sw_h = 1; m_ev = 1; end
            else if (m_sw_h && rx_level <= rw) begin m_sw_h = 0; m_ev = 2; end
            m_ctsok = !cfg_auto_cts || cts_i;
            act = cfg_sw_en && cfg_rx_sel != 0;
            m_flags = 0; m_wr = 0; done = 0; c = rx_char;
            if (rx_valid) begin
                m_wr = 1; m_wrd = c;
                if (act && cfg_rx_sel == 2'b01) begin
                    if (c == xoff2_chr) begin m_flags = 8; m_wr = 0; m_paused = 1; end
                    else if (c == xon2_chr) begin m_flags = 2; m_wr = 0; m_paused = 0; end
                end else if (act && cfg_rx_sel == 2'b10) begin
                    if (c == xoff1_chr) begin m_flags = 4; m_wr = 0; m_paused = 1; end
                    else if (c == xon1_chr) begin m_flags = 1; m_wr = 0; m_paused = 0; end
                end else if (act && cfg_rx_sel == 2'b11) begin
                    if (m_poff && c == xoff2_chr) begin m_flags = 12; m_wr = 0; m_paused = 1; done = 1; end
                    else if (m_pon && c == xon2_chr) begin m_flags = 3; m_wr = 0; m_paused = 0; done = 1; end
                end
            end
            if (!(act && cfg_rx_sel == 2'b11)) begin m_pon = 0; m_poff = 0; end
            else if (rx_valid) begin
                m_poff = !done && c == xoff1_chr;
                m_pon  = !done && c == xon1_chr;
            end
            if (!act) m_paused = 0;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input string what, input int act_v, input int exp_v);
        n_checks++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    task automatic compare();
        chk(cur_req, "rts_o", rts_o, !m_rts_h);
        chk(cur_req, "tx_allow", tx_allow, m_ctsok && !m_paused);
        chk(cur_req, "send_req", send_req, m_q.size() > 0);
        if (m_q.size() > 0) chk(cur_req, "send_char", send_char, m_q[0]);
        chk(cur_req, "spc_flags", spc_flags, m_flags);
        chk(cur_req, "rx_wr", rx_wr, m_wr);
        if (m_wr) chk(cur_req, "rx_wr_data", rx_wr_data, m_wrd);
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic rx_send(input logic [7:0] ch);
        rx_valid = 1; rx_char = ch;
        tick();
        rx_valid = 0;
    endtask

    task automatic ack();
        send_ack = 1;
        tick();
        send_ack = 0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL %s watchdog actual=running expected=finished", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        chk("R1", "rts_o in reset", rts_o, 1);
        chk("R1", "tx_allow in reset", tx_allow, 1);
        chk("R1", "send_req in reset", send_req, 0);
        chk("R1", "flags in reset", spc_flags, 0);
        rst_n = 1;
        tick(2);

        // R2 / R3: hysteresis on request-to-send, halt 32 words, resume 16 words
        cur_req = "R2";
        cfg_auto_rts = 1; flow_lvl = 8'h24;
        for (int l = 0; l <= 40; l += 4) begin rx_level = 8'(l); tick(); end
        chk("R2", "rts_o after level 40", rts_o, 0);
        cur_req = "R3";
        rx_level = 20; tick(2);
        chk("R3", "rts_o held above resume", rts_o, 0);
        rx_level = 16; tick();
        chk("R3", "rts_o at resume", rts_o, 1);
        rx_level = 31; tick();
        chk("R3", "rts_o below halt", rts_o, 1);
        rx_level = 32; tick();
        chk("R2", "rts_o exactly at halt", rts_o, 0);

        // R4: zero halt field means 128 words; manual mode
        cur_req = "R4";
        rx_level = 0; tick();
        flow_lvl = 8'h40; rx_level = 127; tick();
        chk("R4", "rts_o at 127 with halt field 0", rts_o, 1);
        rx_level = 128; tick();
        chk("R4", "rts_o at 128 with halt field 0", rts_o, 0);
        cfg_auto_rts = 0; tick();
        chk("R4", "rts_o manual", rts_o, 1);
        rx_level = 0; tick();

        // R5: clear-to-send gate
        cur_req = "R5";
        cfg_auto_cts = 1; cts_i = 0; tick();
        chk("R5", "tx_allow cts low", tx_allow, 0);
        cts_i = 1; tick();
        chk("R5", "tx_allow cts high", tx_allow, 1);
        cfg_auto_cts = 0; cts_i = 0; tick(2);
        chk("R5", "tx_allow cts ignored", tx_allow, 1);
        cts_i = 1;

        // R6: single-set matching
        cur_req = "R6";
        cfg_sw_en = 1; cfg_rx_sel = 2'b10;
        rx_send(XOFF1);
        chk("R6", "flags first pause", spc_flags, 4'b0100);
        chk("R6", "pause not stored", rx_wr, 0);
        chk("R9", "tx_allow paused", tx_allow, 0);
        rx_send(8'h41);
        chk("R6", "plain char stored", rx_wr, 1);
        chk("R6", "plain char data", rx_wr_data, 8'h41);
        rx_send(XOFF2);
        chk("R6", "second-set char passes in set1 mode", rx_wr, 1);
        rx_send(XON1);
        chk("R6", "flags first resume", spc_flags, 4'b0001);
        chk("R9", "tx_allow resumed", tx_allow, 1);
        cfg_rx_sel = 2'b01;
        rx_send(XOFF2);
        chk("R6", "flags second pause", spc_flags, 4'b1000);
        cur_req = "R9";
        cfg_auto_cts = 1; cts_i = 0; rx_send(XON2);
        chk("R9", "cts closed while resumed", tx_allow, 0);
        cts_i = 1; tick();
        chk("R9", "both gates open", tx_allow, 1);
        cfg_auto_cts = 0;

        // R7: pair matching
        cur_req = "R7";
        cfg_rx_sel = 2'b11;
        rx_send(XOFF1);
        chk("R7", "first half stored", rx_wr, 1);
        chk("R7", "first half no flag", spc_flags, 0);
        rx_send(XOFF2);
        chk("R7", "pause pair flags", spc_flags, 4'b1100);
        chk("R7", "pause pair tx_allow", tx_allow, 0);
        rx_send(XON1); rx_send(8'h55); rx_send(XON2);
        chk("R7", "broken pair no flag", spc_flags, 0);
        chk("R7", "broken pair stays paused", tx_allow, 0);
        rx_send(XON1); rx_send(XON2);
        chk("R7", "resume pair flags", spc_flags, 4'b0011);
        chk("R7", "resume pair tx_allow", tx_allow, 1);

        // R8: matching disabled
        cur_req = "R8";
        cfg_rx_sel = 2'b10; rx_send(XOFF1);
        cfg_sw_en = 0; tick();
        chk("R8", "pause cleared when disabled", tx_allow, 1);
        rx_send(XOFF1);
        chk("R8", "stored when disabled", rx_wr, 1);
        chk("R8", "no flag when disabled", spc_flags, 0);
        cfg_sw_en = 1; cfg_rx_sel = 2'b00; rx_send(XON1);
        chk("R8", "no flag with select 00", spc_flags, 0);

        // R10 / R11 / R12: emitted characters
        cur_req = "R10";
        flow_lvl = 8'h24; cfg_tx_sel = 2'b11; rx_level = 0; tick(2);
        rx_level = 32; tick(2);
        chk("R10", "send_req after halt", send_req, 1);
        chk("R10", "first pause first", send_char, XOFF1);
        cur_req = "R12";
        tick(3);
        chk("R12", "held without ack", send_char, XOFF1);
        ack();
        chk("R12", "second char after ack", send_char, XOFF2);
        ack();
        chk("R12", "queue empty", send_req, 0);
        cur_req = "R11";
        rx_level = 16; tick(2);
        chk("R11", "resume queued", send_char, XON1);
        ack(); ack();
        cfg_tx_sel = 2'b01; rx_level = 40; tick(2);
        chk("R10", "second-set pause only", send_char, XOFF2);
        ack();
        chk("R10", "single char done", send_req, 0);
        cfg_tx_sel = 2'b10; rx_level = 8; tick(2);
        chk("R11", "first-set resume", send_char, XON1);
        ack();

        // R13: replacement of a pending queue
        cur_req = "R13";
        cfg_tx_sel = 2'b11; rx_level = 48; tick(2);
        rx_level = 0; tick(2);
        chk("R13", "queue replaced by resume", send_char, XON1);
        ack(); ack();

        // Mixed stimulus against the model
        cur_req = "R9";
        for (int i = 0; i < 4000; i++) begin
            if (i % 97 == 0) begin
                cfg_auto_rts = 1'($urandom); cfg_auto_cts = 1'($urandom);
                cfg_sw_en = ($urandom % 4) != 0;
                cfg_rx_sel = 2'($urandom); cfg_tx_sel = 2'($urandom);
                flow_lvl = 8'($urandom);
            end
            if ($urandom % 5 == 0) rx_level = 8'($urandom % 129);
            cts_i = ($urandom % 4) != 0;
            send_ack = ($urandom % 3) == 0;
            rx_valid = 1'($urandom);
            case ($urandom % 6)
                0: rx_char = XON1;
                1: rx_char = XON2;
                2: rx_char = XOFF1;
                3: rx_char = XOFF2;
                default: rx_char = 8'($urandom);
            endcase
            tick();
        end
        rx_valid = 0; send_ack = 0;
        finish_run();
    end
endmodule